// File: doc/BRIEF.md
# Memory-Mapped Slave Bus Decoder with Byte-Lane Adapter

This block sits between one bus master, typically a CPU core, and a small set of memory-mapped slaves. The master presents an address, write data, a two-bit access size and separate read and write strobes. It holds that request until the block returns a one-cycle acknowledge. The block decodes the address into a one-hot slave select, forwards the request to that slave, and returns the slave's completion, error status and read data to the master one cycle after the slave completes.

Sub-word data is right-aligned on the master side in both directions. Only the address carries the byte offset. A lane adapter moves store data into the correct byte lanes of a word-organised slave, produces matching byte enables, and shifts load data back down with zero extension. Requests that the block can reject by itself are completed locally with an error and never reach a slave. These are a reserved size code, a misaligned access, both strobes set at once, or an address that falls in no slave window.

Top module: `periph_bus_decoder`

## Requirements
- R1: Size code 00 is a byte, 01 a half word, 10 a word and 11 is reserved. Slave byte enables are 4'b0001 shifted left by address[1:0] for a byte, 4'b0011 shifted left by address[1:0] for a half word, and 4'b1111 for a word. Bit b enables data bits [8b+7:8b].
- R2: Slave write data is the master write data shifted left by 8×address[1:0], with every byte outside the enabled lanes forced to zero. The slave address is the master address with bits [1:0] cleared.
- R3: Read data from a successful read is the slave word shifted right by 8×address[1:0] and zero-extended above bit 7 for a byte or bit 15 for a half word. For example, byte 0xAA written at offset 1 reads back as 0x000000AA.
- R4: Slave k matches when (address AND mask k) equals base k. When several windows match, the lowest index wins, and at most one select is high. Defaults: slave 0 is 0x0000_0000/0xFFFF_0000, slave 1 is 0x1000_0000/0xFFFF_F000, slave 2 is 0x1000_0000/0xF000_0000.
- R5: A select is driven only while a read or write strobe is high and the request has no local error. It is low in the cycle in which the master sees acknowledge.
- R6: A reserved size code, a half word at an odd address, a word whose address[1:0] is nonzero, or both strobes high together drives no select. The block raises acknowledge and error together in the cycle after the request is first seen, with read data zero.
- R7: An address matching no window behaves as in R6: no select, acknowledge and error one cycle later, and read data zero.
- R8: When the selected slave raises its acknowledge or error, the master sees acknowledge exactly one cycle later, together with the slave's error. Acknowledge is a single-cycle pulse for each request.
- R9: Master read data is zero in every cycle without acknowledge, and also on acknowledges for writes or errors.
- R10: During and just after reset, acknowledge, error and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_addr_i | input | 32 | Master byte address |
| m_wdata_i | input | 32 | Master write data, right-aligned |
| m_size_i | input | 2 | Access size code |
| m_ren_i | input | 1 | Read request strobe |
| m_wen_i | input | 1 | Write request strobe |
| m_rdata_o | output | 32 | Right-aligned read data, valid with acknowledge |
| m_ack_o | output | 1 | Request complete |
| m_err_o | output | 1 | Request failed, valid with acknowledge |
| s_sel_o | output | N_SLV | One-hot slave selects |
| s_addr_o | output | 32 | Word-aligned slave address |
| s_wdata_o | output | 32 | Lane-positioned write data |
| s_be_o | output | 4 | Byte enables |
| s_ren_o | output | 1 | Read strobe to selected slave |
| s_wen_o | output | 1 | Write strobe to selected slave |
| s_rdata_i | input | 32×N_SLV | Slave read words, slave k at bits [32k+31:32k] |
| s_ack_i | input | N_SLV | Slave acknowledges |
| s_err_i | input | N_SLV | Slave errors |

## Verification
Random reads and writes of every size and offset are spread over all three windows. Byte lanes that are written and then read back separate correct lane steering and zero extension from shifts in the wrong direction or missing masks. The slaves have different completion latencies of 0, 2 and 1 cycles, so an acknowledge taken from the wrong slave or the wrong cycle shows up as a latency mismatch. Directed cases cover the overlapping windows, which test priority. They also cover the reserved size code, odd and unaligned addresses, both strobes set together, holes in the map, and a slave-reported error, which tell local rejection apart from slave rejection.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  function automatic logic bad_align(size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return |off;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pbd_addr_decode.sv
module pbd_addr_decode
  import pbd_pkg::*;
#(
  parameter int N_SLV = 3,
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_BASE = '0,
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_MASK = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  size_e             size_i,
  input  logic              ren_i,
  input  logic              wen_i,
  output logic [N_SLV-1:0]  sel_o,
  output logic              err_o
);
  logic [N_SLV-1:0] match;

  for (genvar k = 0; k < N_SLV; k++) begin : g_match
    assign match[k] = ((addr_i & SLV_MASK[k]) == SLV_BASE[k]);
  end

  // lowest index wins on overlap
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel_o = '0;
    for (int k = 0; k < N_SLV; k++) begin
      if (match[k] && !taken) begin
        sel_o[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign err_o = bad_align(size_i, addr_i[OFF_W-1:0]) | (ren_i & wen_i) | ~|match;
endmodule

// File: rtl/pbd_lane_adapt.sv
module pbd_lane_adapt
  import pbd_pkg::*;
(
  input  size_e             size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  input  logic [DATA_W-1:0] s_word_i,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] s_wdata_o,
  output logic [DATA_W-1:0] m_rdata_o
);
  localparam logic [BE_W-1:0] BE_ONE  = BE_W'(1);
  localparam logic [BE_W-1:0] BE_HALF = BE_W'(3);

  logic [BE_W-1:0]   be_base;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] word_shr;

  always_comb begin
    case (size_i)
      SZ_BYTE: be_base = BE_ONE;
      SZ_HALF: be_base = BE_HALF;
      SZ_WORD: be_base = '1;
      default: be_base = '0;
    endcase
  end

  assign be_o = be_base << off_i;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{be_o[b]}};
    assign size_mask[b*8 +: 8] = {8{be_base[b]}};
  end

  assign s_wdata_o = (m_wdata_i << {off_i, 3'b000}) & lane_mask;
  assign word_shr  = s_word_i >> {off_i, 3'b000};
  assign m_rdata_o = word_shr & size_mask;
endmodule

// File: rtl/pbd_resp_reg.sv
module pbd_resp_reg
  import pbd_pkg::*;
#(
  parameter int N_SLV = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ren_i,
  input  logic                          wen_i,
  input  logic [N_SLV-1:0]              dec_sel_i,
  input  logic                          dec_err_i,
  input  logic [N_SLV-1:0][DATA_W-1:0]  s_rdata_i,
  input  logic [N_SLV-1:0]              s_ack_i,
  input  logic [N_SLV-1:0]              s_err_i,
  input  logic [DATA_W-1:0]             rdata_al_i,
  output logic [N_SLV-1:0]              sel_o,
  output logic [DATA_W-1:0]             s_word_o,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          ack_o,
  output logic                          err_o
);
  logic active, slv_done, slv_fail, fire, fail, load;

  // request is idle in the cycle its acknowledge is shown
  assign active = (ren_i | wen_i) & ~ack_o;
  assign sel_o  = (active & ~dec_err_i) ? dec_sel_i : '0;

  always_comb begin
    s_word_o = '0;
    for (int k = 0; k < N_SLV; k++) begin
      if (sel_o[k]) s_word_o = s_word_o | s_rdata_i[k];
    end
  end

  assign slv_done = |(sel_o & (s_ack_i | s_err_i));
  assign slv_fail = |(sel_o & s_err_i);
  assign fire     = active & (dec_err_i | slv_done);
  assign fail     = active & (dec_err_i | slv_fail);
  assign load     = fire & ~fail & ren_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= fire;
      err_o   <= fail;
      rdata_o <= load ? rdata_al_i : '0;
    end
  end

  AST_ACK_PULSE:   assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |=> !ack_o);              // R8
  AST_ERR_IN_ACK:  assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> ack_o);               // R6
  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !ack_o |-> rdata_o == '0);      // R9
  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> rdata_o == '0);       // R9
endmodule

// File: rtl/periph_bus_decoder.sv
module periph_bus_decoder
  import pbd_pkg::*;
#(
  parameter int N_SLV = 3,
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_BASE = {32'h1000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_MASK = {32'hF000_0000, 32'hFFFF_F000, 32'hFFFF_0000}
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       m_addr_i,
  input  logic [DATA_W-1:0]       m_wdata_i,
  input  logic [1:0]              m_size_i,
  input  logic                    m_ren_i,
  input  logic                    m_wen_i,
  output logic [DATA_W-1:0]       m_rdata_o,
  output logic                    m_ack_o,
  output logic                    m_err_o,
  output logic [N_SLV-1:0]        s_sel_o,
  output logic [ADDR_W-1:0]       s_addr_o,
  output logic [DATA_W-1:0]       s_wdata_o,
  output logic [BE_W-1:0]         s_be_o,
  output logic                    s_ren_o,
  output logic                    s_wen_o,
  input  logic [N_SLV*DATA_W-1:0] s_rdata_i,
  input  logic [N_SLV-1:0]        s_ack_i,
  input  logic [N_SLV-1:0]        s_err_i
);
  size_e                         size;
  logic [N_SLV-1:0]              dec_sel;
  logic                          dec_err;
  logic [DATA_W-1:0]             s_word;
  logic [DATA_W-1:0]             rdata_al;
  logic [N_SLV-1:0][DATA_W-1:0]  s_rdata_arr;

  assign size        = size_e'(m_size_i);
  assign s_rdata_arr = s_rdata_i;

  pbd_addr_decode #(
    .N_SLV    (N_SLV),
    .SLV_BASE (SLV_BASE),
    .SLV_MASK (SLV_MASK)
  ) u_dec (
    .addr_i (m_addr_i),
    .size_i (size),
    .ren_i  (m_ren_i),
    .wen_i  (m_wen_i),
    .sel_o  (dec_sel),
    .err_o  (dec_err)
  );

  pbd_lane_adapt u_lane (
    .size_i    (size),
    .off_i     (m_addr_i[OFF_W-1:0]),
    .m_wdata_i (m_wdata_i),
    .s_word_i  (s_word),
    .be_o      (s_be_o),
    .s_wdata_o (s_wdata_o),
    .m_rdata_o (rdata_al)
  );

  pbd_resp_reg #(.N_SLV(N_SLV)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ren_i      (m_ren_i),
    .wen_i      (m_wen_i),
    .dec_sel_i  (dec_sel),
    .dec_err_i  (dec_err),
    .s_rdata_i  (s_rdata_arr),
    .s_ack_i    (s_ack_i),
    .s_err_i    (s_err_i),
    .rdata_al_i (rdata_al),
    .sel_o      (s_sel_o),
    .s_word_o   (s_word),
    .rdata_o    (m_rdata_o),
    .ack_o      (m_ack_o),
    .err_o      (m_err_o)
  );

  assign s_addr_o = {m_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign s_ren_o  = m_ren_i & |s_sel_o;
  assign s_wen_o  = m_wen_i & |s_sel_o;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(s_sel_o));                                   // R4
  AST_BE_SHAPE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (|s_sel_o) |-> ($countones(s_be_o) == 1 || $countones(s_be_o) == 2 || $countones(s_be_o) == 4));     // R1
  AST_NO_SEL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni) (m_ren_i & m_wen_i) |-> s_sel_o == '0);             // R6
  AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(m_ack_o) |-> $past(m_ren_i | m_wen_i));      // R8
endmodule

// File: tb/periph_bus_decoder_test.sv
module periph_bus_decoder_test;
  localparam int NS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [1:0]  m_size = '0;
  logic        m_ren = 1'b0, m_wen = 1'b0;
  logic [31:0] m_rdata;
  logic        m_ack, m_err;
  logic [NS-1:0] s_sel;
  logic [31:0] s_addr, s_wdata;
  logic [3:0]  s_be;
  logic        s_ren, s_wen;
  logic [NS*32-1:0] s_rdata;
  logic [NS-1:0] s_ack, s_err;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periph_bus_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_size_i(m_size), .m_ren_i(m_ren), .m_wen_i(m_wen),
    .m_rdata_o(m_rdata), .m_ack_o(m_ack), .m_err_o(m_err),
    .s_sel_o(s_sel), .s_addr_o(s_addr), .s_wdata_o(s_wdata), .s_be_o(s_be),
    .s_ren_o(s_ren), .s_wen_o(s_wen),
    .s_rdata_i(s_rdata), .s_ack_i(s_ack), .s_err_i(s_err)
  );

  // slave models: word memories with fixed completion latency
  localparam int LAT [NS] = '{0, 2, 1};
  logic [31:0] mem [NS][16];
  int cnt [NS];

  function automatic bit slv_bad(int k, logic [31:0] a);
    return (k == 2) && (a[5:2] == 4'hF);
  endfunction

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      s_ack[k] = s_sel[k] && !slv_bad(k, s_addr) && (cnt[k] == LAT[k]);
      s_err[k] = s_sel[k] &&  slv_bad(k, s_addr) && (cnt[k] == LAT[k]);
      s_rdata[k*32 +: 32] = mem[k][s_addr[5:2]];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (!rst_n) begin
        cnt[k] <= 0;
        for (int w = 0; w < 16; w++) mem[k][w] <= '0;
      end else begin
        if (!s_sel[k]) cnt[k] <= 0;
        else if (cnt[k] < LAT[k]) cnt[k] <= cnt[k] + 1;
        if (s_ack[k] && s_wen)
          for (int b = 0; b < 4; b++)
            if (s_be[b]) mem[k][s_addr[5:2]][b*8 +: 8] <= s_wdata[b*8 +: 8];
      end
    end
  end

  logic [7:0] shadow [NS][64];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_slave(logic [31:0] a);
    if (a[31:16] == 16'h0000) return 0;
    if (a[31:12] == 20'h10000) return 1;
    if (a[31:28] == 4'h1) return 2;
    return -1;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'b00: return 4'b0001 << off;
      2'b01: return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic txn(logic [31:0] a, logic [31:0] wd, logic [1:0] sz, logic rd, logic wr);
    int es, n, exp_n;
    bit lerr, serr;
    logic [3:0] be;
    logic [31:0] ew, er;
    es   = exp_slave(a);
    lerr = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 0) || (rd && wr) || (es < 0);
    serr = !lerr && slv_bad(es, a);
    be   = exp_be(sz, a[1:0]);
    ew   = '0;
    for (int b = 0; b < 4; b++) if (be[b]) ew[b*8 +: 8] = wd[(b - a[1:0])*8 +: 8];
    @(negedge clk);
    m_addr = a; m_wdata = wd; m_size = sz; m_ren = rd; m_wen = wr;
    #1;
    if (lerr) begin
      chk(es < 0 ? "R7 sel" : "R6 sel", 32'(s_sel), 32'h0);
    end else begin
      chk("R4 sel", 32'(s_sel), 32'(1) << es);
      chk("R1 be", 32'(s_be), 32'(be));
      chk("R2 addr", s_addr, {a[31:2], 2'b00});
      if (wr) chk("R2 wdata", s_wdata, ew);
    end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!m_ack && n < 30);
    exp_n = lerr ? 1 : LAT[es] + 1;
    chk(lerr ? "R6/R7 latency" : "R8 latency", n, exp_n);
    chk("R8 err", 32'(m_err), 32'(lerr || serr));
    chk("R5 sel in ack", 32'(s_sel), 32'h0);
    er = '0;
    if (rd && !lerr && !serr)
      for (int b = 0; b < 4; b++) if (be[b]) er[(b - a[1:0])*8 +: 8] = shadow[es][{a[5:2], 2'(b)}];
    chk(rd ? "R3 rdata" : "R9 rdata", m_rdata, er);
    if (wr && !lerr && !serr)
      for (int b = 0; b < 4; b++) if (be[b]) shadow[es][{a[5:2], 2'(b)}] = wd[(b - a[1:0])*8 +: 8];
    m_ren = 1'b0; m_wen = 1'b0;
    @(negedge clk);
    chk("R8 single ack", 32'(m_ack), 32'h0);
    chk("R9 idle rdata", m_rdata, 32'h0);
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0, 1, 7: return {16'h0000, r[15:0]};
      2, 3:    return {20'h10000, r[11:0]};
      4, 5:    return 32'h1000_1000 | {4'h0, r[27:0]};
      default: return 32'h3000_0000 | {4'h0, r[27:0]};
    endcase
  endfunction

  initial begin
    for (int k = 0; k < NS; k++) for (int i = 0; i < 64; i++) shadow[k][i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 ack in reset", 32'(m_ack), 32'h0);
    chk("R10 err in reset", 32'(m_err), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rdata after reset", m_rdata, 32'h0);
    // directed corners
    txn(32'h0000_0001, 32'hFFFF_FFAA, 2'b00, 1'b0, 1'b1);   // R2 byte at lane 1
    txn(32'h0000_0001, 32'h0, 2'b00, 1'b1, 1'b0);           // R3 reads 0x000000AA
    txn(32'h0000_0006, 32'h1234_BEEF, 2'b01, 1'b0, 1'b1);   // R1 upper half
    txn(32'h0000_0004, 32'h0, 2'b10, 1'b1, 1'b0);           // R3 word
    txn(32'h0000_0006, 32'h0, 2'b01, 1'b1, 1'b0);           // R3 half
    txn(32'h0000_0003, 32'h0, 2'b01, 1'b1, 1'b0);           // R6 odd half
    txn(32'h0000_0002, 32'h0, 2'b10, 1'b0, 1'b1);           // R6 unaligned word
    txn(32'h0000_0000, 32'h0, 2'b11, 1'b1, 1'b0);           // R6 reserved size
    txn(32'h0000_0000, 32'h0, 2'b10, 1'b1, 1'b1);           // R6 both strobes
    txn(32'h0001_0000, 32'h0, 2'b10, 1'b1, 1'b0);           // R7 hole above slave 0
    txn(32'h2000_0000, 32'h0, 2'b00, 1'b0, 1'b1);           // R7 unmapped
    txn(32'h1000_0008, 32'hCAFE_F00D, 2'b10, 1'b0, 1'b1);   // R4 overlap -> slave 1
    txn(32'h1000_1008, 32'h0BAD_0BAD, 2'b10, 1'b0, 1'b1);   // R4 catch-all -> slave 2
    txn(32'h1000_0008, 32'h0, 2'b10, 1'b1, 1'b0);
    txn(32'h1000_103C, 32'h0, 2'b10, 1'b1, 1'b0);           // R8 slave error
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic rd;
      sz = ($urandom % 16 == 15) ? 2'b11 : 2'($urandom % 3);
      rd = ($urandom % 2) == 0;
      txn(rand_addr(), $urandom, sz, rd, !rd);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule